// File: doc/BRIEF.md
# Packed Saturating Add-Subtract Unit

This block performs one lane-parallel integer operation on two packed vectors per clock. A vector is 128 bits (wide mode) or 64 bits (narrow mode), split into 8-bit or 16-bit lanes. Each lane is computed independently. Results that leave the lane's range are clamped instead of wrapping. The operations are:

- add and subtract, with either unsigned or signed saturation
- the unsigned average, rounded half up
- unsigned and signed minimum and maximum

The operands, the operation code, the lane-size select and the width select are presented together. The result appears on `result` after one rising clock edge. Each lane is evaluated in an 18-bit datapath, so an overflow past the top of the range is never confused with an underflow below the bottom.

Top module: `psat_alu`

## Requirements
- R1: While `rst_n` is low, `result` is all zeros at each rising edge.
- R2: Op code 0 (unsigned saturating add) returns the lane sum, or all ones in that lane when the sum exceeds the lane range (0xF0+0x20 gives 0xFF).
- R3: Op code 1 (unsigned saturating subtract) returns the difference, or zero when it would be negative (0x48-0xD7 gives 0x00).
- R4: Op codes 2 (signed add) and 3 (signed subtract) clamp each lane to 0x7F/0x80 for bytes and 0x7FFF/0x8000 for words.
- R5: Op code 4 returns (a+b+1)>>1 per lane as unsigned values, with no lost carry (0xFF,0xFF gives 0xFF; 0x01,0x02 gives 0x02).
- R6: Op codes 5 (unsigned minimum) and 6 (unsigned maximum) select a lane value by unsigned comparison.
- R7: Op codes 7 (signed minimum) and 8 (signed maximum) select a lane value by two's-complement comparison. Equal operands return that same value.
- R8: `lane16`=0 selects 8-bit lanes and `lane16`=1 selects 16-bit lanes. Carries and clamps never cross a lane boundary.
- R9: With `wide`=0, `result[127:64]` is zero and `op_b[127:64]` has no effect on the result. With `wide`=1, all 128 bits are computed.
- R10: `result` changes only at a rising edge and reflects the inputs sampled at that edge, with one cycle of latency.
- R11: Op codes 9 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 128 | Destination (first) operand vector |
| op_b | input | 128 | Source (second) operand vector |
| op_sel | input | 4 | Operation code, see R2 to R11 |
| lane16 | input | 1 | 0: 8-bit lanes, 1: 16-bit lanes |
| wide | input | 1 | 0: 64-bit vector, 1: 128-bit vector |
| result | output | 128 | Registered result vector |

## Verification
The operations are exercised with operands placed just inside and just outside each lane's range. These vectors separate a wrapping implementation from a clamping one, and an overflow clamp from an underflow clamp. The 0x80 versus 0x7F and 0x8000 versus 0x7FFF pairs are run through both the signed and the unsigned min/max. Those two comparisons give opposite answers on these pairs, so a swapped comparison kind shows up. The same operands are applied in byte and word lane size to expose carries leaking across a byte boundary. The average is checked at the all-ones corner, where a narrow adder would drop the carry. Directed steps check the narrow-mode upper half (including a non-zero `op_b[127:64]` that must be ignored), the unused op codes, reset, and that a new input has no effect until the next edge.

// File: rtl/psat_alu.sv
module psat_alu #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [3:0]       op_sel,
  input  logic             lane16,
  input  logic             wide,
  output logic [VEC_W-1:0] result
);
  localparam int NBYTE = VEC_W / 8;
  localparam int NWORD = VEC_W / 16;
  localparam int HALF  = VEC_W / 2;

  localparam logic [3:0] ADDU = 4'd0, SUBU = 4'd1, ADDS = 4'd2, SUBS = 4'd3,
                         AVGU = 4'd4, MINU = 4'd5, MAXU = 4'd6, MINS = 4'd7,
                         MAXS = 4'd8;

  function automatic logic [15:0] lane_calc(input logic [15:0] x, input logic [15:0] y,
                                            input logic w16, input logic [3:0] op);
    logic [17:0] ux, uy, sx, sy, t, hi, lo;
    logic [15:0] umax, smax, smin, r;
    ux   = w16 ? {2'b0, x} : {10'b0, x[7:0]};
    uy   = w16 ? {2'b0, y} : {10'b0, y[7:0]};
    sx   = w16 ? {{2{x[15]}}, x} : {{10{x[7]}}, x[7:0]};
    sy   = w16 ? {{2{y[15]}}, y} : {{10{y[7]}}, y[7:0]};
    umax = w16 ? 16'hFFFF : 16'h00FF;
    smax = w16 ? 16'h7FFF : 16'h007F;
    smin = w16 ? 16'h8000 : 16'h0080;
    hi   = {2'b0, smax};
    lo   = w16 ? 18'h38000 : 18'h3FF80;
    t    = '0;
    r    = '0;
    case (op)
      ADDU: begin t = ux + uy; r = (t > {2'b0, umax}) ? umax : t[15:0]; end
      SUBU: begin t = ux - uy; r = t[17] ? 16'h0 : t[15:0]; end
      ADDS, SUBS: begin
        t = (op == ADDS) ? sx + sy : sx - sy;
        if ($signed(t) > $signed(hi))      r = smax;
        else if ($signed(t) < $signed(lo)) r = smin;
        else                               r = t[15:0];
      end
      AVGU: begin t = ux + uy + 18'd1; r = t[16:1]; end
      MINU: r = (ux < uy) ? x : y;
      MAXU: r = (ux > uy) ? x : y;
      MINS: r = ($signed(sx) < $signed(sy)) ? x : y;
      MAXS: r = ($signed(sx) > $signed(sy)) ? x : y;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] byte_calc(input logic [7:0] x, input logic [7:0] y,
                                           input logic [3:0] op);
    logic [15:0] r;
    r = lane_calc({8'b0, x}, {8'b0, y}, 1'b0, op);
    return r[7:0];
  endfunction

  logic [VEC_W-1:0] byte_res, word_res, full_res, next_res;

  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    assign byte_res[8*k +: 8] = byte_calc(op_a[8*k +: 8], op_b[8*k +: 8], op_sel);
  end

  for (genvar k = 0; k < NWORD; k++) begin : g_word
    assign word_res[16*k +: 16] = lane_calc(op_a[16*k +: 16], op_b[16*k +: 16], 1'b1, op_sel);
  end

  assign full_res = lane16 ? word_res : byte_res;
  assign next_res = wide ? full_res : {{HALF{1'b0}}, full_res[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) result <= '0;
    else        result <= next_res;
  end
endmodule

// File: rtl/psat_alu_chk.sv
module psat_alu_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VEC_W-1:0] op_a,
  input logic [VEC_W-1:0] op_b,
  input logic [3:0]       op_sel,
  input logic             lane16,
  input logic             wide,
  input logic [VEC_W-1:0] result
);
  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> result == '0);

  p_addu_not_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd0 && !lane16) |=> result[7:0] >= $past(op_a[7:0]));

  p_subu_not_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd1 && !lane16) |=> result[7:0] <= $past(op_a[7:0]));

  p_adds_sign_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd2 && !lane16 && op_a[7] == op_b[7]) |=> result[7] == $past(op_a[7]));

  p_maxu_dominates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd6 && lane16) |=>
      (result[15:0] >= $past(op_a[15:0]) && result[15:0] >= $past(op_b[15:0])));

  p_narrow_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |=> result[VEC_W-1:VEC_W/2] == '0);

  p_unused_op_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 4'd8) |=> result == '0);
endmodule

bind psat_alu psat_alu_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_psat_alu.sv
module sim_psat_alu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [3:0]   op_sel = '0;
  logic         lane16 = 1'b0, wide = 1'b1;
  logic [127:0] result;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  psat_alu u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
               .lane16(lane16), .wide(wide), .result(result));

  // entry: {req[3:0], op[3:0], lane16, wide, a[127:0], b[127:0], expected[127:0]}
  localparam int NV = 21;
  localparam logic [393:0] VEC [NV] = '{
    {4'd2, 4'd0, 1'b0, 1'b1, {16{8'hF0}}, {16{8'h20}}, {16{8'hFF}}},        // R2 clamp
    {4'd2, 4'd0, 1'b0, 1'b1, {16{8'h10}}, {16{8'h20}}, {16{8'h30}}},        // R2 plain
    {4'd3, 4'd1, 1'b0, 1'b1, {16{8'h48}}, {16{8'hD7}}, 128'h0},             // R3 clamp
    {4'd3, 4'd1, 1'b1, 1'b1, {8{16'h1234}}, {8{16'h0034}}, {8{16'h1200}}},  // R3 plain
    {4'd4, 4'd2, 1'b0, 1'b1, {16{8'h70}}, {16{8'h20}}, {16{8'h7F}}},        // R4 high
    {4'd4, 4'd2, 1'b0, 1'b1, {16{8'h90}}, {16{8'hE0}}, {16{8'h80}}},        // R4 low
    {4'd4, 4'd3, 1'b1, 1'b1, {8{16'h8000}}, {8{16'h0001}}, {8{16'h8000}}},  // R4 word low
    {4'd4, 4'd3, 1'b1, 1'b1, {8{16'h7FFF}}, {8{16'hFFFF}}, {8{16'h7FFF}}},  // R4 word high
    {4'd4, 4'd3, 1'b0, 1'b1, {16{8'h05}}, {16{8'h03}}, {16{8'h02}}},        // R4 plain
    {4'd5, 4'd4, 1'b0, 1'b1, {8{16'h01FF}}, {8{16'h02FF}}, {8{16'h02FF}}},  // R5 byte
    {4'd5, 4'd4, 1'b1, 1'b1, {4{32'h0001FFFF}}, {4{32'h0002FFFF}}, {4{32'h0002FFFF}}}, // R5 word
    {4'd6, 4'd6, 1'b0, 1'b1, {16{8'h80}}, {16{8'h7F}}, {16{8'h80}}},        // R6 max
    {4'd6, 4'd5, 1'b1, 1'b1, {8{16'h8000}}, {8{16'h7FFF}}, {8{16'h7FFF}}},  // R6 min
    {4'd7, 4'd8, 1'b1, 1'b1, {8{16'h8000}}, {8{16'h7FFF}}, {8{16'h7FFF}}},  // R7 max
    {4'd7, 4'd7, 1'b0, 1'b1, {16{8'h80}}, {16{8'h7F}}, {16{8'h80}}},        // R7 min
    {4'd7, 4'd7, 1'b1, 1'b1, {8{16'hC3A5}}, {8{16'hC3A5}}, {8{16'hC3A5}}},  // R7 equal
    {4'd8, 4'd0, 1'b1, 1'b1, {8{16'h00FF}}, {8{16'h0001}}, {8{16'h0100}}},  // R8 word carry
    {4'd8, 4'd0, 1'b0, 1'b1, {8{16'h00FF}}, {8{16'h0001}}, {8{16'h00FF}}},  // R8 byte clamp
    {4'd9, 4'd0, 1'b0, 1'b0, {16{8'h10}}, {16{8'h20}}, {64'h0, {8{8'h30}}}}, // R9 narrow
    {4'd9, 4'd0, 1'b0, 1'b0, {16{8'h10}}, {{8{8'hF0}}, {8{8'h20}}}, {64'h0, {8{8'h30}}}}, // R9 upper b ignored
    {4'd11, 4'd15, 1'b1, 1'b1, {16{8'h33}}, {16{8'h44}}, 128'h0}            // R11
  };

  task automatic check(input int req, input logic [127:0] exp, input string what);
    n_chk++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, result, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 128'h0, "reset state");  // R1
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op_sel = VEC[i][389:386];
      lane16 = VEC[i][385];
      wide   = VEC[i][384];
      op_a   = VEC[i][383:256];
      op_b   = VEC[i][255:128];
      @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][393:390]), VEC[i][127:0], $sformatf("vector %0d", i));
    end

    // R10: new inputs have no effect before the edge, then appear after one edge
    op_sel = 4'd0; lane16 = 1'b0; wide = 1'b1;
    op_a = {16{8'h01}}; op_b = {16{8'h01}};
    @(posedge clk); @(negedge clk);
    check(10, {16{8'h02}}, "first value");
    op_a = {16{8'h05}};
    #2;
    check(10, {16{8'h02}}, "held before edge");
    @(posedge clk); @(negedge clk);
    check(10, {16{8'h06}}, "updated after edge");

    // R1: reset mid-run clears the result
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1, 128'h0, "reset mid-run");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);

    finish_run();
  end
endmodule